// File: doc/BRIEF.md
# Integer Register File with Delayed Branch-Compare Reads

This block holds the sixteen 16-bit integer registers on the scalar side of a small vector coprocessor. Every clock cycle in which the stall input is low counts as one issued instruction. The issue side supplies the decoded fields for that instruction: two source specifiers, a destination specifier, a write flag with write data, and a two-bit class tag. Two ordinary read ports return the current contents of the registers named by the source specifiers.

A second pair of outputs feeds the branch comparator. Suppose a conditional branch reads a register, and the instruction issued just before it wrote that same register with an ordinary write. In that case the comparator receives the value the register held before the four most recently issued instructions. Writes to that register inside the four-instruction window are skipped, whatever form they take. The rule does not apply when the preceding write was a flag transfer, when the instruction is a register jump, or when the register was not written just before. In those cases the comparator sees the current value.

The history counts every issued instruction, including branches and delay-slot instructions. A loop that branches back can therefore see a value written during its previous pass.

Top module: `int_rf_brhist`

## Requirements
- R1: After reset every register reads zero on both ordinary read ports and on both branch-compare outputs.
- R2: Specifiers are 5 bits wide, and only their low 4 bits select a register. For example, specifier 18 selects register 2 for reads and for writes.
- R3: Register 0 always reads zero. A write to it, whether through specifier 0 or 16, is discarded.
- R4: An issued instruction with its write flag set updates the destination register at the clock edge. The ordinary read ports show the new value from the next cycle on.
- R5: A cycle with the stall input high is not an issued instruction. It writes nothing and does not advance the branch-read history.
- R6: Class 2'b10 is a conditional branch. When the previous issued instruction was an ordinary write (class other than 2'b01) to the register that a branch operand names, that branch-compare output returns the register's value from before the four most recently issued instructions.
- R7: A conditional branch whose operand register was not written by the previous issued instruction receives the current value on that branch-compare output.
- R8: For classes other than 2'b10, including the register jump class 2'b11, the branch-compare outputs equal the current register values.
- R9: Class 2'b01 is a flag transfer. When the previous issued instruction was a flag transfer that wrote the branch's operand register, the branch receives the newly written value.
- R10: Branches and delay-slot instructions count toward the four-instruction window. On a second pass through a loop, the branch can receive a value written during the first pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| iss_stall | input | 1 | High: no instruction issues this cycle |
| iss_cls | input | 2 | Class: 00 ordinary, 01 flag transfer, 10 conditional branch, 11 register jump |
| iss_src_a | input | 5 | First source specifier |
| iss_src_b | input | 5 | Second source specifier |
| iss_dst | input | 5 | Destination specifier |
| iss_wen | input | 1 | The instruction writes its destination |
| iss_wdata | input | 16 | Write data |
| rd_a | output | 16 | Current value of the first source |
| rd_b | output | 16 | Current value of the second source |
| br_a | output | 16 | Branch-compare value of the first source |
| br_b | output | 16 | Branch-compare value of the second source |

## Verification
The bench builds the block with its default values: 16-bit data, sixteen registers, 5-bit specifiers and a history depth of four. At these values the specifier masking for 16 to 31 can be reached, and so can the four-instruction window, which is crossed by stalls, flag transfers and loop back-edges. The random part confines destinations and sources to a few low registers. This makes back-to-back write-then-branch pairs and repeated writes inside the window frequent.

// File: rtl/int_rf_pkg.sv
package int_rf_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_FLAG   = 2'd1,
    CLS_BRANCH = 2'd2,
    CLS_JUMP   = 2'd3
  } iss_cls_e;
endpackage

// File: rtl/int_rf_regs.sv
module int_rf_regs #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [DATA_W-1:0] old_data
);
  logic [DATA_W-1:0] regs_val [NUM_REGS];

  // Entry 0 is a hard zero; the other entries each carry their own enable.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign regs_val[g] = '0;
    end else begin : g_reg
      logic              ent_we;
      logic [DATA_W-1:0] ent_q;
      always_comb begin
        ent_we = wr_en && (wr_idx == IDX_W'(g));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q <= '0;
        end else if (ent_we) begin
          ent_q <= wr_data;
        end
      end
      assign regs_val[g] = ent_q;
    end
  end

  always_comb begin
    rd_data_a = regs_val[rd_idx_a];
    rd_data_b = regs_val[rd_idx_b];
    old_data  = regs_val[wr_idx];
  end
endmodule

// File: rtl/int_rf_hist.sv
module int_rf_hist #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv,
  input  logic                          in_wen,
  input  logic                          in_flag,
  input  logic [IDX_W-1:0]              in_idx,
  input  logic [DATA_W-1:0]             in_old,
  output logic [DEPTH-1:0]              h_wen,
  output logic [DEPTH-1:0]              h_flag,
  output logic [DEPTH-1:0][IDX_W-1:0]   h_idx,
  output logic [DEPTH-1:0][DATA_W-1:0]  h_old
);
  // Slot 0 is the most recently issued instruction.
  logic [DEPTH-1:0]             wen_d, flag_d;
  logic [DEPTH-1:0][IDX_W-1:0]  idx_d;
  logic [DEPTH-1:0][DATA_W-1:0] old_d;

  always_comb begin
    wen_d[0]  = in_wen;
    flag_d[0] = in_flag;
    idx_d[0]  = in_idx;
    old_d[0]  = in_old;
    for (int k = 1; k < DEPTH; k++) begin
      wen_d[k]  = h_wen[k-1];
      flag_d[k] = h_flag[k-1];
      idx_d[k]  = h_idx[k-1];
      old_d[k]  = h_old[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_wen  <= '0;
      h_flag <= '0;
      h_idx  <= '0;
      h_old  <= '0;
    end else if (adv) begin
      h_wen  <= wen_d;
      h_flag <= flag_d;
      h_idx  <= idx_d;
      h_old  <= old_d;
    end
  end
endmodule

// File: rtl/int_rf_brview.sv
module int_rf_brview #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic                          is_branch,
  input  logic [IDX_W-1:0]              src,
  input  logic [DATA_W-1:0]             cur,
  input  logic [DEPTH-1:0]              h_wen,
  input  logic [DEPTH-1:0]              h_flag,
  input  logic [DEPTH-1:0][IDX_W-1:0]   h_idx,
  input  logic [DEPTH-1:0][DATA_W-1:0]  h_old,
  output logic [DATA_W-1:0]             val
);
  logic              trig;
  logic [DATA_W-1:0] older;

  always_comb begin
    trig  = is_branch && h_wen[0] && !h_flag[0] && (h_idx[0] == src);
    // Walk newest to oldest; the oldest matching write holds the pre-window value.
    older = cur;
    for (int k = 0; k < DEPTH; k++) begin
      if (h_wen[k] && (h_idx[k] == src)) begin
        older = h_old[k];
      end
    end
    val = trig ? older : cur;
  end
endmodule

// File: rtl/int_rf_brhist.sv
module int_rf_brhist #(
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 16,
  parameter int SPEC_W     = 5,
  parameter int HIST_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_stall,
  input  logic [1:0]        iss_cls,
  input  logic [SPEC_W-1:0] iss_src_a,
  input  logic [SPEC_W-1:0] iss_src_b,
  input  logic [SPEC_W-1:0] iss_dst,
  input  logic              iss_wen,
  input  logic [DATA_W-1:0] iss_wdata,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [DATA_W-1:0] br_a,
  output logic [DATA_W-1:0] br_b
);
  import int_rf_pkg::*;
  localparam int IDX_W = $clog2(NUM_REGS);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  iss_cls_e         cls;
  logic [IDX_W-1:0] src_idx [2];
  logic [DATA_W-1:0] cur_val [2];
  logic [DATA_W-1:0] br_val  [2];
  logic [IDX_W-1:0] dst_idx;
  logic             issue, do_write, is_branch;
  logic [DATA_W-1:0] old_val;

  always_comb begin
    cls        = iss_cls_e'(iss_cls);
    src_idx[0] = iss_src_a[IDX_W-1:0];
    src_idx[1] = iss_src_b[IDX_W-1:0];
    dst_idx    = iss_dst[IDX_W-1:0];
    issue      = !iss_stall;
    do_write   = issue && iss_wen && (dst_idx != '0);
    is_branch  = (cls == CLS_BRANCH);
  end

  int_rf_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (do_write),
    .wr_idx    (dst_idx),
    .wr_data   (iss_wdata),
    .rd_idx_a  (src_idx[0]),
    .rd_idx_b  (src_idx[1]),
    .rd_data_a (cur_val[0]),
    .rd_data_b (cur_val[1]),
    .old_data  (old_val)
  );

  logic [HIST_DEPTH-1:0]             h_wen, h_flag;
  logic [HIST_DEPTH-1:0][IDX_W-1:0]  h_idx;
  logic [HIST_DEPTH-1:0][DATA_W-1:0] h_old;

  int_rf_hist #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv     (issue),
    .in_wen  (do_write),
    .in_flag (cls == CLS_FLAG),
    .in_idx  (dst_idx),
    .in_old  (old_val),
    .h_wen   (h_wen),
    .h_flag  (h_flag),
    .h_idx   (h_idx),
    .h_old   (h_old)
  );

  for (genvar p = 0; p < 2; p++) begin : g_brport
    int_rf_brview #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(HIST_DEPTH)) u_view (
      .is_branch (is_branch),
      .src       (src_idx[p]),
      .cur       (cur_val[p]),
      .h_wen     (h_wen),
      .h_flag    (h_flag),
      .h_idx     (h_idx),
      .h_old     (h_old),
      .val       (br_val[p])
    );
  end

  always_comb begin
    rd_a = cur_val[0];
    rd_b = cur_val[1];
    br_a = br_val[0];
    br_b = br_val[1];
  end
endmodule

// File: rtl/int_rf_brhist_chk.sv
module int_rf_brhist_chk #(
  parameter int DATA_W = 16,
  parameter int SPEC_W = 5
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              iss_stall,
  input logic [1:0]        iss_cls,
  input logic [SPEC_W-1:0] iss_src_a,
  input logic [SPEC_W-1:0] iss_dst,
  input logic              iss_wen,
  input logic [DATA_W-1:0] iss_wdata,
  input logic [DATA_W-1:0] rd_a,
  input logic [DATA_W-1:0] br_a
);
  AST_ZERO_REG_READS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iss_src_a[3:0] == 4'd0) |-> (rd_a == '0)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!iss_stall && iss_wen && iss_dst[3:0] != 4'd0) |=>
      (iss_src_a[3:0] != $past(iss_dst[3:0]) || rd_a == $past(iss_wdata))); // R4

  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    iss_stall |=> (iss_src_a[3:0] != $past(iss_src_a[3:0]) || rd_a == $past(rd_a))); // R5

  AST_NO_PRIOR_WRITE_CURRENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iss_cls == 2'd2 && $past(!iss_stall) &&
     !($past(iss_wen) && $past(iss_dst[3:0]) == iss_src_a[3:0])) |-> (br_a == rd_a)); // R7

  AST_NON_BRANCH_CURRENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iss_cls != 2'd2) |-> (br_a == rd_a)); // R8

  AST_FLAG_WRITE_CURRENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iss_cls == 2'd2 && $past(!iss_stall && iss_cls == 2'd1 && iss_wen) &&
     iss_src_a[3:0] == $past(iss_dst[3:0])) |-> (br_a == rd_a)); // R9
endmodule

bind int_rf_brhist int_rf_brhist_chk #(.DATA_W(DATA_W), .SPEC_W(SPEC_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .iss_stall  (iss_stall),
  .iss_cls    (iss_cls),
  .iss_src_a  (iss_src_a),
  .iss_dst    (iss_dst),
  .iss_wen    (iss_wen),
  .iss_wdata  (iss_wdata),
  .rd_a       (rd_a),
  .br_a       (br_a)
);

// File: tb/int_rf_brhist_bench.sv
`timescale 1ns/1ps
module int_rf_brhist_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_stall;
  logic [1:0]  iss_cls;
  logic [4:0]  iss_src_a, iss_src_b, iss_dst;
  logic        iss_wen;
  logic [15:0] iss_wdata;
  logic [15:0] rd_a, rd_b, br_a, br_b;

  always #10 clk = ~clk; // 50 MHz

  int_rf_brhist u_int_rf_brhist (
    .clk (clk), .rst_n (rst_n), .iss_stall (iss_stall), .iss_cls (iss_cls),
    .iss_src_a (iss_src_a), .iss_src_b (iss_src_b), .iss_dst (iss_dst),
    .iss_wen (iss_wen), .iss_wdata (iss_wdata),
    .rd_a (rd_a), .rd_b (rd_b), .br_a (br_a), .br_b (br_b)
  );

  localparam logic [1:0] C_PLAIN = 2'd0, C_FLAG = 2'd1, C_BR = 2'd2, C_JMP = 2'd3;

  // snap[k][r]: register r before the k most recent issued instructions (k=0: now).
  logic [15:0] snap [5][16];
  logic        last_wen, last_flag;
  logic [3:0]  last_idx;
  int          n_checks = 0, n_fail = 0;
  bit          done = 0;

  function automatic logic [15:0] cur(input logic [4:0] s);
    return snap[0][s[3:0]];
  endfunction

  function automatic logic [15:0] exp_br(input logic [1:0] c, input logic [4:0] s);
    if (c == C_BR && last_wen && !last_flag && last_idx == s[3:0])
      return snap[4][s[3:0]];
    return snap[0][s[3:0]];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [4:0] sa, input logic [4:0] sb,
                      input logic [4:0] d, input logic we, input logic [15:0] wd,
                      input logic st, input string tag);
    @(negedge clk);
    iss_cls = c; iss_src_a = sa; iss_src_b = sb; iss_dst = d;
    iss_wen = we; iss_wdata = wd; iss_stall = st;
    #2;
    chk(tag, "rd_a", rd_a, cur(sa));
    chk(tag, "rd_b", rd_b, cur(sb));
    chk(tag, "br_a", br_a, exp_br(c, sa));
    chk(tag, "br_b", br_b, exp_br(c, sb));
    if (!st) begin
      for (int k = 4; k > 0; k--)
        for (int r = 0; r < 16; r++) snap[k][r] = snap[k-1][r];
      last_wen  = we && (d[3:0] != 4'd0);
      last_flag = (c == C_FLAG);
      last_idx  = d[3:0];
      if (last_wen) snap[0][d[3:0]] = wd;
    end
  endtask

  task automatic nop(input string tag);
    step(C_PLAIN, 5'd0, 5'd0, 5'd0, 1'b0, 16'h0, 1'b0, tag);
  endtask

  task automatic wr(input logic [4:0] d, input logic [15:0] v, input string tag);
    step(C_PLAIN, 5'd0, 5'd0, d, 1'b1, v, 1'b0, tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    for (int k = 0; k < 5; k++) for (int r = 0; r < 16; r++) snap[k][r] = '0;
    last_wen = 0; last_flag = 0; last_idx = '0;
    rst_n = 0; iss_stall = 1; iss_cls = C_PLAIN; iss_src_a = 0; iss_src_b = 0;
    iss_dst = 0; iss_wen = 0; iss_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state on all four outputs
    step(C_BR, 5'd5, 5'd15, 5'd0, 1'b0, 16'h0, 1'b1, "R1");
    step(C_PLAIN, 5'd1, 5'd9, 5'd0, 1'b0, 16'h0, 1'b1, "R1");

    // R2: specifier 18 writes register 2, read back via 2 and 18
    wr(5'd18, 16'hA5A5, "R2");
    step(C_PLAIN, 5'd2, 5'd18, 5'd0, 1'b0, 16'h0, 1'b0, "R2");

    // R3: writes through 0 and 16 are discarded
    wr(5'd0, 16'h1234, "R3");
    wr(5'd16, 16'h4321, "R3");
    step(C_BR, 5'd0, 5'd16, 5'd0, 1'b0, 16'h0, 1'b0, "R3");

    // R4 / R6: write r2=4, r1=4, r1=7, nops, r1=20, branch -> r1 seen as 4
    wr(5'd2, 16'd4, "R4");
    nop("R4"); nop("R4");
    wr(5'd1, 16'd4, "R4");
    wr(5'd1, 16'd7, "R4");
    nop("R4"); nop("R4");
    wr(5'd1, 16'd20, "R4");
    step(C_BR, 5'd1, 5'd2, 5'd0, 1'b0, 16'h0, 1'b0, "R6");
    chk("R6", "br_a literal", br_a, 16'd4);

    // R7: branch with no write just before sees current value
    nop("R7");
    step(C_BR, 5'd1, 5'd2, 5'd0, 1'b0, 16'h0, 1'b0, "R7");
    chk("R7", "br_a literal", br_a, 16'd20);

    // R8: register jump after a write sees the current value
    wr(5'd1, 16'd33, "R8");
    step(C_JMP, 5'd1, 5'd1, 5'd0, 1'b0, 16'h0, 1'b0, "R8");
    chk("R8", "br_a literal", br_a, 16'd33);

    // R9: flag-transfer write right before branch is visible
    step(C_FLAG, 5'd0, 5'd0, 5'd3, 1'b1, 16'h0FFF, 1'b0, "R9");
    step(C_BR, 5'd3, 5'd0, 5'd0, 1'b0, 16'h0, 1'b0, "R9");
    chk("R9", "br_a literal", br_a, 16'h0FFF);

    // R5: stalled writes change nothing and do not advance the window
    wr(5'd5, 16'd1, "R5");
    wr(5'd5, 16'd2, "R5");
    wr(5'd5, 16'd3, "R5");
    wr(5'd5, 16'd4, "R5");
    wr(5'd5, 16'd5, "R5");
    step(C_PLAIN, 5'd5, 5'd5, 5'd5, 1'b1, 16'd99, 1'b1, "R5");
    step(C_PLAIN, 5'd5, 5'd5, 5'd5, 1'b1, 16'd98, 1'b1, "R5");
    step(C_BR, 5'd5, 5'd5, 5'd0, 1'b0, 16'h0, 1'b0, "R5");
    chk("R5", "br_a literal", br_a, 16'd1);

    // R10: loop with a delay-slot write; second pass sees first-pass value
    wr(5'd2, 16'd100, "R10");
    wr(5'd3, cur(5'd2) + 16'd251, "R10");
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 3; i++) wr(5'd2, cur(5'd2) + 16'd1, "R10");
      step(C_BR, 5'd3, 5'd2, 5'd0, 1'b0, 16'h0, 1'b0, "R10");
      chk("R10", "br_b literal", br_b, pass == 0 ? 16'd100 : 16'd103);
      wr(5'd2, cur(5'd2) + 16'd1, "R10");
    end

    // Random mix (R4, R6, R7, R8, R9 by situation)
    void'($urandom(32'd20240611));
    for (int i = 0; i < 800; i++) begin
      logic [1:0] c;
      logic [4:0] sa, sb, d;
      logic st, we;
      c  = 2'($urandom_range(0, 3));
      sa = {($urandom_range(0, 7) == 0), 2'b00, 2'($urandom_range(0, 3))};
      sb = 5'($urandom_range(0, 31));
      d  = {($urandom_range(0, 7) == 0), 2'b00, 2'($urandom_range(0, 3))};
      we = ($urandom_range(0, 3) != 0);
      st = ($urandom_range(0, 7) == 0);
      v  = 16'($urandom);
      step(c, sa, sb, d, we, v, st,
           c == C_BR ? "R6" : (c == C_JMP ? "R8" : (c == C_FLAG ? "R9" : "R4")));
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule